// File: doc/BRIEF.md
# SIMD Lane Shift, Rotate and Shuffle Unit

This unit processes one 64-bit operand as a set of independent lanes. The lanes are 16, 32 or 64 bits wide. Four kinds of shift work inside every lane, and one shift count applies to all lanes: logical right, logical left, arithmetic right and rotate right. No bit ever moves from one lane into a neighbouring lane. The unit also has two operations that rearrange data. A halfword shuffle builds each result halfword from the source halfword that an 8-bit selector names. A byte-align funnel joins two operands and extracts a 64-bit window from the pair at a byte offset.

The datapath is combinational and feeds an output register. When the valid strobe is high at a clock edge, the register captures the result and a per-lane sign/zero status word. The result appears on the outputs one cycle after the strobe. A pulse marks that cycle. When the strobe is low, the outputs hold their values.

Top module: `simd_lane_shifter`

## Requirements
- R1: Reset clears `res_o`, `flags_o` and `vld_o` to zero, and they stay zero until the first strobe.
- R2: Logical right shift (op 0) and logical left shift (op 1) move each lane by `count_i` and fill the vacated bits with zeros. No bit passes between lanes. A count equal to or greater than the lane width gives zero in every lane. Lane width codes: 0 selects 16 bits, 1 selects 32 bits, and 2 or 3 selects 64 bits.
- R3: Arithmetic right shift (op 2) fills each lane from that lane's own top bit. A count equal to or greater than the lane width fills the whole lane with its sign bit.
- R4: Rotate right (op 3) rotates each lane by `count_i` modulo the lane width. A count of 0 returns the lane unchanged, and the rotate never changes the number of set bits.
- R5: Shuffle (op 4) puts source halfword number `sel_i[2k+1:2k]` into result halfword k (k = 0..3, halfword 0 = bits 15:0). The width select has no effect on this operation.
- R6: Byte-align (op 5) returns the low 64 bits of `{opb_i, opa_i}` shifted right by 8·n bits, where n = `count_i[2:0]`. When n = 0 the result is `opa_i`.
- R7: Shift, rotate and shuffle operations write the status word. Flag pair p occupies bits 2p+1 (N) and 2p (Z). Each lane reports in the pair that belongs to its most significant halfword: pairs 0..3 for 16-bit lanes, pairs 1 and 3 for 32-bit lanes, and pair 3 for the 64-bit lane. All other pairs are zero. N is the top bit of the lane, and Z is set when the lane is all zero. Shuffle always uses the 16-bit mapping.
- R8: `res_o` and `flags_o` update at the clock edge where `valid_i` is high. `vld_o` is high during exactly the cycle that follows each strobe.
- R9: With no strobe, `res_o` and `flags_o` hold their values. Byte-align and the reserved ops (6, 7) leave `flags_o` unchanged. The reserved ops return `opa_i` as the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that captures the operation |
| op_i | input | 3 | Operation select |
| width_i | input | 2 | Lane width select |
| count_i | input | 6 | Shift/rotate count; low 3 bits give the align byte count |
| sel_i | input | 8 | Shuffle selector, 2 bits per result halfword |
| opa_i | input | 64 | Primary operand |
| opb_i | input | 64 | Second operand, used only by byte-align |
| res_o | output | 64 | Registered result |
| flags_o | output | 8 | Registered per-lane N/Z status |
| vld_o | output | 1 | High for the cycle after a strobe |

## Verification
The bench targets counts at or beyond the lane width, where a design that relies on bare shift operators might leak bits into the next lane or return a partial shift instead of zero or full sign fill. It also checks rotate counts of 0 and counts that exceed the lane width: a wrong design would rotate the whole word or fail to wrap the count. Two further checks cover a shuffle whose selector reverses the halfwords, and an align count whose low bits are zero. Last, the bench confirms that flags survive align and the reserved ops, and that 32- and 64-bit lanes report only in their upper pairs; a wrong mapping would place the flags in the wrong bit positions.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

  typedef enum logic [2:0] {
    OP_SRL   = 3'd0,
    OP_SLL   = 3'd1,
    OP_SRA   = 3'd2,
    OP_ROR   = 3'd3,
    OP_SHUF  = 3'd4,
    OP_ALIGN = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } shop_e;

  localparam logic [1:0] LSEL_16 = 2'd0;
  localparam logic [1:0] LSEL_32 = 2'd1;
  localparam logic [1:0] LSEL_64 = 2'd2;

  localparam int unsigned N_BANKS = 3;

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit import simd_shift_pkg::*; #(
  parameter int unsigned LW    = 16,
  parameter int unsigned CNT_W = 6
) (
  input  logic [LW-1:0]    lane_i,
  input  logic [2:0]       op_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LW-1:0]    lane_o
);

  localparam int unsigned RW = $clog2(LW);
  localparam logic [CNT_W:0] LW_C = (CNT_W+1)'(LW);

  function automatic logic over_width(logic [CNT_W-1:0] n);
    return ({1'b0, n} >= LW_C);
  endfunction

  function automatic logic [LW-1:0] f_srl(logic [LW-1:0] v, logic [CNT_W-1:0] n);
    return over_width(n) ? '0 : (v >> n);
  endfunction

  function automatic logic [LW-1:0] f_sll(logic [LW-1:0] v, logic [CNT_W-1:0] n);
    return over_width(n) ? '0 : (v << n);
  endfunction

  function automatic logic [LW-1:0] f_sra(logic [LW-1:0] v, logic [CNT_W-1:0] n);
    logic [LW-1:0] s;
    s = $signed(v) >>> n;
    return over_width(n) ? {LW{v[LW-1]}} : s;
  endfunction

  function automatic logic [LW-1:0] f_ror(logic [LW-1:0] v, logic [CNT_W-1:0] n);
    logic [2*LW-1:0] d;
    d = {v, v} >> n[RW-1:0];
    return d[LW-1:0];
  endfunction

  always_comb begin
    case (shop_e'(op_i))
      OP_SRL:  lane_o = f_srl(lane_i, cnt_i);
      OP_SLL:  lane_o = f_sll(lane_i, cnt_i);
      OP_SRA:  lane_o = f_sra(lane_i, cnt_i);
      OP_ROR:  lane_o = f_ror(lane_i, cnt_i);
      default: lane_o = lane_i;
    endcase
  end

endmodule

// File: rtl/simd_hw_shuffle.sv
module simd_hw_shuffle #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HW     = 16
) (
  input  logic [DATA_W-1:0]                              src_i,
  input  logic [(DATA_W/HW)*$clog2(DATA_W/HW)-1:0]       sel_i,
  output logic [DATA_W-1:0]                              dst_o
);

  localparam int unsigned NH = DATA_W / HW;
  localparam int unsigned SW = $clog2(NH);

  logic [HW-1:0] hw [NH];

  for (genvar j = 0; j < NH; j++) begin : g_split
    assign hw[j] = src_i[j*HW +: HW];
  end

  for (genvar k = 0; k < NH; k++) begin : g_pick
    assign dst_o[k*HW +: HW] = hw[sel_i[k*SW +: SW]];
  end

endmodule

// File: rtl/simd_byte_align.sv
module simd_byte_align #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]                 lo_i,
  input  logic [DATA_W-1:0]                 hi_i,
  input  logic [$clog2(DATA_W/8)-1:0]       nbytes_i,
  output logic [DATA_W-1:0]                 win_o
);

  localparam int unsigned BW = $clog2(DATA_W/8);

  logic [2*DATA_W-1:0] funnel;

  assign funnel = {hi_i, lo_i} >> {nbytes_i, 3'b000};
  assign win_o  = funnel[DATA_W-1:0];

endmodule

// File: rtl/simd_flag_map.sv
module simd_flag_map import simd_shift_pkg::*; #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HW     = 16
) (
  input  logic [DATA_W-1:0]          res_i,
  input  logic [1:0]                 lsel_i,
  output logic [2*(DATA_W/HW)-1:0]   flags_o
);

  localparam int unsigned NP = DATA_W / HW;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic n16, z16, n32, z32, n64, z64;

    assign n16 = res_i[(p+1)*HW-1];
    assign z16 = ~|res_i[p*HW +: HW];

    if (p % 2 == 1) begin : g_w32
      assign n32 = res_i[(p+1)*HW-1];
      assign z32 = ~|res_i[(p-1)*HW +: 2*HW];
    end else begin : g_w32_off
      assign n32 = 1'b0;
      assign z32 = 1'b0;
    end

    if (p == NP-1) begin : g_w64
      assign n64 = res_i[DATA_W-1];
      assign z64 = ~|res_i;
    end else begin : g_w64_off
      assign n64 = 1'b0;
      assign z64 = 1'b0;
    end

    always_comb begin
      case (lsel_i)
        LSEL_16: flags_o[2*p +: 2] = {n16, z16};
        LSEL_32: flags_o[2*p +: 2] = {n32, z32};
        default: flags_o[2*p +: 2] = {n64, z64};
      endcase
    end
  end

endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter import simd_shift_pkg::*; #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HW     = 16,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned NH     = DATA_W / HW,
  parameter int unsigned SEL_W  = NH * $clog2(NH),
  parameter int unsigned FLAG_W = 2 * NH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        width_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              vld_o
);

  localparam int unsigned AB_W = $clog2(DATA_W/8);

  shop_e op_e;
  assign op_e = shop_e'(op_i);

  // One bank of lane units per lane width
  logic [N_BANKS-1:0][DATA_W-1:0] bank_res;

  for (genvar wi = 0; wi < N_BANKS; wi++) begin : g_bank
    localparam int unsigned LW = HW << wi;
    localparam int unsigned NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane_unit #(.LW(LW), .CNT_W(CNT_W)) u_lane (
        .lane_i (opa_i[l*LW +: LW]),
        .op_i   (op_i),
        .cnt_i  (count_i),
        .lane_o (bank_res[wi][l*LW +: LW])
      );
    end
  end

  logic [1:0] bank_idx;
  assign bank_idx = (width_i == 2'd3) ? LSEL_64 : width_i;

  logic [DATA_W-1:0] shuf_res;
  simd_hw_shuffle #(.DATA_W(DATA_W), .HW(HW)) u_shuf (
    .src_i (opa_i),
    .sel_i (sel_i),
    .dst_o (shuf_res)
  );

  logic [DATA_W-1:0] align_res;
  simd_byte_align #(.DATA_W(DATA_W)) u_align (
    .lo_i     (opa_i),
    .hi_i     (opb_i),
    .nbytes_i (count_i[AB_W-1:0]),
    .win_o    (align_res)
  );

  // Named internal events for the assertions
  logic [DATA_W-1:0] nxt_res;
  logic              flag_wr;
  logic [1:0]        flag_lsel;
  logic [FLAG_W-1:0] nxt_flags;

  always_comb begin
    case (op_e)
      OP_SRL, OP_SLL, OP_SRA, OP_ROR: nxt_res = bank_res[bank_idx];
      OP_SHUF:                        nxt_res = shuf_res;
      OP_ALIGN:                       nxt_res = align_res;
      default:                        nxt_res = opa_i;
    endcase
  end

  assign flag_wr   = (op_e == OP_SRL) || (op_e == OP_SLL) || (op_e == OP_SRA) ||
                     (op_e == OP_ROR) || (op_e == OP_SHUF);
  assign flag_lsel = (op_e == OP_SHUF) ? LSEL_16 : bank_idx;

  simd_flag_map #(.DATA_W(DATA_W), .HW(HW)) u_flags (
    .res_i   (nxt_res),
    .lsel_i  (flag_lsel),
    .flags_o (nxt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      flags_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        res_o <= nxt_res;
        if (flag_wr) flags_o <= nxt_flags;
      end
    end
  end

  // Assertions
  assert_srl_over_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_e == OP_SRL && width_i == LSEL_16 && count_i >= CNT_W'(HW))
      |-> (nxt_res == '0));

  assert_sra_full_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_e == OP_SRA && bank_idx == LSEL_64 && (&count_i))
      |-> (nxt_res == {DATA_W{opa_i[DATA_W-1]}}));

  assert_ror_keeps_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_e == OP_ROR) |-> ($countones(nxt_res) == $countones(opa_i)));

  assert_align_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_e == OP_ALIGN && count_i[AB_W-1:0] == '0) |-> (nxt_res == opa_i));

  assert_wide_flags_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_idx == LSEL_64 && op_e != OP_SHUF) |-> (nxt_flags[FLAG_W-3:0] == '0));

  assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> vld_o);

  assert_no_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !vld_o);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(res_o) && $stable(flags_o)));

  assert_align_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= 3'd5) |=> $stable(flags_o));

endmodule

// File: tb/simd_lane_shifter_bench.sv
module simd_lane_shifter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  localparam logic [63:0] AV = 64'h8001_4000_00F0_FFFF;
  localparam logic [63:0] BV = 64'h1122_3344_5566_7788;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  wid;
    logic [5:0]  cnt;
    logic [7:0]  sel;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 6'd4,  8'h00, 64'h0800_0400_000F_0FFF}, // R2 srl 16
    '{3'd1, 2'd0, 6'd4,  8'h00, 64'h0010_0000_0F00_FFF0}, // R2 sll 16
    '{3'd2, 2'd0, 6'd4,  8'h00, 64'hF800_0400_000F_FFFF}, // R3 sra 16
    '{3'd3, 2'd0, 6'd4,  8'h00, 64'h1800_0400_000F_FFFF}, // R4 ror 16
    '{3'd0, 2'd1, 6'd8,  8'h00, 64'h0080_0140_0000_F0FF}, // R2 srl 32
    '{3'd2, 2'd1, 6'd20, 8'h00, 64'hFFFF_F800_0000_000F}, // R3 sra 32
    '{3'd3, 2'd1, 6'd36, 8'h00, 64'h0800_1400_F00F_0FFF}, // R4 ror 32 wraps
    '{3'd1, 2'd2, 6'd12, 8'h00, 64'h1400_000F_0FFF_F000}, // R2 sll 64
    '{3'd2, 2'd2, 6'd63, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF}, // R3 sra 64 max
    '{3'd0, 2'd0, 6'd16, 8'h00, 64'h0000_0000_0000_0000}, // R2 over width
    '{3'd2, 2'd0, 6'd20, 8'h00, 64'hFFFF_0000_0000_FFFF}, // R3 over width
    '{3'd3, 2'd2, 6'd0,  8'h00, AV},                      // R4 count 0
    '{3'd4, 2'd2, 6'd0,  8'hAA, 64'h4000_4000_4000_4000}, // R5 broadcast
    '{3'd4, 2'd2, 6'd0,  8'h1B, 64'hFFFF_00F0_4000_8001}, // R5 reverse
    '{3'd5, 2'd0, 6'd3,  8'h00, 64'h6677_8880_0140_0000}, // R6 three bytes
    '{3'd5, 2'd1, 6'd8,  8'h00, AV},                      // R6 n = 0
    '{3'd6, 2'd0, 6'd4,  8'h00, AV},                      // R9 reserved
    '{3'd1, 2'd1, 6'd31, 8'h00, 64'h0000_0000_8000_0000}, // R2 sll 32
    '{3'd0, 2'd3, 6'd4,  8'h00, 64'h0800_1400_000F_0FFF}  // R2 code 3 = 64
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  width_i = '0;
  logic [5:0]  count_i = '0;
  logic [7:0]  sel_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [63:0] res_o;
  logic [7:0]  flags_o;
  logic        vld_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_shifter u_simd_lane_shifter (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .width_i(width_i),
    .count_i(count_i), .sel_i(sel_i), .opa_i(opa_i), .opb_i(opb_i),
    .res_o(res_o), .flags_o(flags_o), .vld_o(vld_o)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Status word restated: a lane reports in the pair ending at its top bit
  function automatic logic [7:0] model_flags(logic [63:0] r, int lw);
    logic [7:0] f;
    f = '0;
    for (int p = 0; p < 4; p++) begin
      int top;
      top = (p + 1) * 16;
      if (top % lw == 0) begin
        logic [63:0] lane;
        lane = r >> (top - lw);
        if (lw < 64) lane = lane & ((64'd1 << lw) - 64'd1);
        f[2*p+1] = r[top-1];
        f[2*p]   = (lane == 64'd0);
      end
    end
    return f;
  endfunction

  function automatic int lane_bits(logic [1:0] code);
    return (code == 2'd0) ? 16 : (code == 2'd1) ? 32 : 64;
  endfunction

  task automatic strobe(vec_t v);
    @(negedge clk);
    op_i = v.op; width_i = v.wid; count_i = v.cnt; sel_i = v.sel;
    opa_i = AV; opb_i = BV; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp_flags;
    exp_flags = '0;
    repeat (3) @(negedge clk);
    check("R1", "res after reset", res_o, 64'd0);
    check("R1", "flags after reset", {56'd0, flags_o}, 64'd0);
    check("R1", "vld after reset", {63'd0, vld_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "res before strobe", res_o, 64'd0);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i]);
      if (VEC[i].op <= 3'd3)
        exp_flags = model_flags(VEC[i].exp, lane_bits(VEC[i].wid));
      else if (VEC[i].op == 3'd4)
        exp_flags = model_flags(VEC[i].exp, 16);
      check($sformatf("R2-9 vec%0d", i), "result", res_o, VEC[i].exp);
      check($sformatf("R7 vec%0d", i), "flags", {56'd0, flags_o}, {56'd0, exp_flags});
      check("R8", "vld pulse", {63'd0, vld_o}, 64'd1);
    end

    // R9: idle cycle with changed inputs keeps outputs; R8: pulse ends
    op_i = 3'd1; width_i = 2'd0; count_i = 6'd1; opa_i = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    check("R9", "idle result hold", res_o, VEC[NV-1].exp);
    check("R9", "idle flags hold", {56'd0, flags_o}, {56'd0, exp_flags});
    check("R8", "vld low after pulse", {63'd0, vld_o}, 64'd0);

    // R1: reset in mid-run clears everything
    strobe(VEC[0]);
    #1 rst_n = 1'b0;
    #1;
    check("R1", "res on reset", res_o, 64'd0);
    check("R1", "flags on reset", {56'd0, flags_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule